// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a virtual address into a physical address in two stages. The top bits of the virtual address pick one of eight segment descriptors held on chip. Each descriptor gives the memory address of that segment's page table, the highest page index the segment may use, and a valid flag. The middle bits are the page index. The translator checks that index against the descriptor and only then reads one page table entry through a memory read port. That entry supplies a physical page number and valid, read and write flags. The low bits pass straight through as the byte offset within a 1 KB page.

Software loads descriptors through a write port. While a load is in progress, and while a translation is in flight, the request side reports not-ready, so a new request waits. Every request ends with exactly one response pulse. The pulse carries either a physical address or an error code that names the failing stage. Two segments that are loaded with the same table address and limit translate the same addresses in the same way, so address spaces can share them.

Top module: `segpg_xlate`

## Requirements
- R1: The 32-bit virtual address splits into a segment field in bits 31:29, a page index in bits 28:10 and a byte offset in bits 9:0.
- R2: When `seg_we` is high at a clock edge, the descriptor selected by `seg_sel` takes `seg_base`, `seg_limit` and `seg_valid`. Reset clears the valid flag of every descriptor.
- R3: A request to a segment whose valid flag is clear responds with code 1 and issues no memory read.
- R4: A page index strictly greater than the segment limit responds with code 2 and issues no memory read. A page index equal to the limit is allowed.
- R5: A request that passes the segment checks issues exactly one single-cycle `mem_rd` pulse, at address `seg_base + 4 * page`.
- R6: A page table entry with bit 0 (valid) clear responds with code 3.
- R7: A read (`req_write`=0) needs entry bit 1 and a write needs entry bit 2. If the needed bit is missing, the response is code 4.
- R8: On success, code is 0, `rsp_err` is low and `rsp_paddr` is the entry's bits 31:12 placed above the 10 offset bits. On any error, `rsp_err` is high and `rsp_paddr` is zero.
- R9: `req_ready` is low whenever `seg_we` is high and while a translation is in flight, so no request is accepted then.
- R10: Two segments loaded with the same base and limit give identical results for the same page and offset.
- R11: After reset, `req_ready` is high and `rsp_valid` and `mem_rd` are low.
- R12: The checks take priority in this order: segment valid, then bound, then entry valid, then permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Descriptor write strobe |
| seg_sel | input | 3 | Descriptor index to write |
| seg_base | input | 32 | Page table address for the descriptor |
| seg_limit | input | 19 | Highest allowed page index |
| seg_valid | input | 1 | Descriptor valid flag |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted at this edge when high |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access type: 1 write, 0 read |
| mem_rd | output | 1 | Page table entry read strobe |
| mem_addr | output | 32 | Byte address of the entry |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 32 | Entry data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_code | output | 3 | 0 ok, 1 bad segment, 2 bound, 3 entry invalid, 4 permission |
| rsp_paddr | output | 30 | Physical address |

## Verification
A vector table drives requests against a fixed set of descriptors and page table entries. Each entry has a different mix of flags, so every error code can be told apart from the others and from success. Some vectors sit exactly at the limit and some one page past it. These separate a correct inclusive bound from an off-by-one. Cases where the entry lacks both valid and read show that the entry valid check wins over the permission check. Comparing a shared segment with its twin, and checking the captured read address, exposes wrong segment decoding and wrong table indexing. Directed steps hold a descriptor load against a waiting request and reset the block mid-run, to show the stall and the clearing of valid flags.

// File: rtl/segpg_pkg.sv
package segpg_pkg;
  typedef enum logic [2:0] {
    XE_NONE  = 3'd0,
    XE_SEG   = 3'd1,
    XE_BOUND = 3'd2,
    XE_PAGE  = 3'd3,
    XE_PERM  = 3'd4
  } xerr_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } xst_e;
endpackage

// File: rtl/segpg_segfile.sv
module segpg_segfile #(
  parameter int SEG_W   = 3,
  parameter int MADDR_W = 32,
  parameter int PAGE_W  = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [SEG_W-1:0]   widx,
  input  logic [MADDR_W-1:0] wbase,
  input  logic [PAGE_W-1:0]  wlimit,
  input  logic               wvalid,
  input  logic               re,
  input  logic [SEG_W-1:0]   ridx,
  output logic [MADDR_W-1:0] rbase,
  output logic [PAGE_W-1:0]  rlimit,
  output logic               rvalid
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int ENT_W = MADDR_W + PAGE_W;

  // base and limit: plain array with synchronous read, RAM inferable
  logic [ENT_W-1:0] ent_mem [NSEG];
  logic [ENT_W-1:0] rd_q;
  logic [NSEG-1:0]  vbits;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (we) ent_mem[widx] <= {wbase, wlimit};
    if (re) rd_q <= ent_mem[ridx];
  end

  // valid flags need reset, so they live in flops
  for (genvar g = 0; g < NSEG; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)                                  vbits[g] <= 1'b0;
      else if (we && (widx == SEG_W'(g)))       vbits[g] <= wvalid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     vld_q <= 1'b0;
    else if (re) vld_q <= vbits[ridx];
  end

  assign rbase  = rd_q[ENT_W-1:PAGE_W];
  assign rlimit = rd_q[PAGE_W-1:0];
  assign rvalid = vld_q;
endmodule

// File: rtl/segpg_bound.sv
module segpg_bound
  import segpg_pkg::*;
#(
  parameter int MADDR_W = 32,
  parameter int PAGE_W  = 19,
  parameter int PTE_W   = 32
) (
  input  logic               seg_ok,
  input  logic [MADDR_W-1:0] base,
  input  logic [PAGE_W-1:0]  limit,
  input  logic [PAGE_W-1:0]  page,
  output xerr_e              code,
  output logic [MADDR_W-1:0] pte_addr
);
  localparam int SH  = $clog2(PTE_W / 8);
  localparam int PAD = MADDR_W - PAGE_W - SH;

  always_comb begin
    if (!seg_ok)           code = XE_SEG;
    else if (page > limit) code = XE_BOUND;
    else                   code = XE_NONE;
  end

  assign pte_addr = base + {{PAD{1'b0}}, page, {SH{1'b0}}};
endmodule

// File: rtl/segpg_pte.sv
module segpg_pte
  import segpg_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int PPN_W = 20
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  output xerr_e            code,
  output logic [PPN_W-1:0] ppn
);
  localparam int FV = 0;
  localparam int FR = 1;
  localparam int FW = 2;

  always_comb begin
    if (!pte[FV])                   code = XE_PAGE;
    else if (is_write && !pte[FW])  code = XE_PERM;
    else if (!is_write && !pte[FR]) code = XE_PERM;
    else                            code = XE_NONE;
  end

  assign ppn = pte[PTE_W-1 -: PPN_W];

  if (PTE_W - PPN_W > 3) begin : g_rsv
    logic unused_rsv;
    assign unused_rsv = ^pte[PTE_W-PPN_W-1:3];
  end
endmodule

// File: rtl/segpg_xlate.sv
module segpg_xlate
  import segpg_pkg::*;
#(
  parameter int SEG_W   = 3,
  parameter int PAGE_W  = 19,
  parameter int OFF_W   = 10,
  parameter int PPN_W   = 20,
  parameter int PTE_W   = 32,
  parameter int MADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          seg_we,
  input  logic [SEG_W-1:0]              seg_sel,
  input  logic [MADDR_W-1:0]            seg_base,
  input  logic [PAGE_W-1:0]             seg_limit,
  input  logic                          seg_valid,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
  input  logic                          req_write,
  output logic                          mem_rd,
  output logic [MADDR_W-1:0]            mem_addr,
  input  logic                          mem_rvalid,
  input  logic [PTE_W-1:0]              mem_rdata,
  output logic                          rsp_valid,
  output logic                          rsp_err,
  output logic [2:0]                    rsp_code,
  output logic [PPN_W+OFF_W-1:0]        rsp_paddr
);
  localparam int VA_W = SEG_W + PAGE_W + OFF_W;
  localparam int PA_W = PPN_W + OFF_W;

  xst_e                 st_q;
  logic [PAGE_W-1:0]    page_q;
  logic [OFF_W-1:0]     off_q;
  logic                 wr_q;
  logic                 accept;

  logic [MADDR_W-1:0]   sf_base;
  logic [PAGE_W-1:0]    sf_limit;
  logic                 sf_valid;
  xerr_e                bc_code;
  logic [MADDR_W-1:0]   bc_addr;
  xerr_e                pc_code;
  logic [PPN_W-1:0]     pc_ppn;

  logic                 mem_rd_q;
  logic [MADDR_W-1:0]   mem_addr_q;
  logic                 rsp_valid_q;
  xerr_e                rsp_code_q;
  logic [PA_W-1:0]      rsp_paddr_q;

  assign req_ready = (st_q == ST_IDLE) && !seg_we;
  assign accept    = req_valid && req_ready;

  segpg_segfile #(
    .SEG_W(SEG_W), .MADDR_W(MADDR_W), .PAGE_W(PAGE_W)
  ) u_segs (
    .clk(clk), .rst(rst),
    .we(seg_we), .widx(seg_sel), .wbase(seg_base),
    .wlimit(seg_limit), .wvalid(seg_valid),
    .re(accept), .ridx(req_vaddr[VA_W-1 -: SEG_W]),
    .rbase(sf_base), .rlimit(sf_limit), .rvalid(sf_valid)
  );

  segpg_bound #(
    .MADDR_W(MADDR_W), .PAGE_W(PAGE_W), .PTE_W(PTE_W)
  ) u_bound (
    .seg_ok(sf_valid), .base(sf_base), .limit(sf_limit),
    .page(page_q), .code(bc_code), .pte_addr(bc_addr)
  );

  segpg_pte #(
    .PTE_W(PTE_W), .PPN_W(PPN_W)
  ) u_pte (
    .pte(mem_rdata), .is_write(wr_q), .code(pc_code), .ppn(pc_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      page_q      <= '0;
      off_q       <= '0;
      wr_q        <= 1'b0;
      mem_rd_q    <= 1'b0;
      mem_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= XE_NONE;
      rsp_paddr_q <= '0;
    end else begin
      mem_rd_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            page_q <= req_vaddr[OFF_W +: PAGE_W];
            off_q  <= req_vaddr[OFF_W-1:0];
            wr_q   <= req_write;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (bc_code != XE_NONE) begin
            rsp_valid_q <= 1'b1;
            rsp_code_q  <= bc_code;
            rsp_paddr_q <= '0;
            st_q        <= ST_IDLE;
          end else begin
            mem_rd_q   <= 1'b1;
            mem_addr_q <= bc_addr;
            st_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            rsp_valid_q <= 1'b1;
            rsp_code_q  <= pc_code;
            rsp_paddr_q <= (pc_code == XE_NONE) ? {pc_ppn, off_q} : '0;
            st_q        <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd    = mem_rd_q;
  assign mem_addr  = mem_addr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_err   = (rsp_code_q != XE_NONE);
  assign rsp_paddr = rsp_paddr_q;
endmodule

// File: rtl/segpg_xlate_chk.sv
module segpg_xlate_chk #(
  parameter int OFF_W = 10,
  parameter int PA_W  = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             seg_we,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_off,
  input logic             mem_rd,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [2:0]       rsp_code,
  input logic [PA_W-1:0]  rsp_paddr
);
  logic [OFF_W-1:0] off_seen;

  always_ff @(posedge clk) begin
    if (rst)                         off_seen <= '0;
    else if (req_valid && req_ready) off_seen <= req_off;
  end

  // R9: no acceptance during a descriptor load
  a_r9_stall_on_load: assert property (@(posedge clk) disable iff (rst)
    seg_we |-> !req_ready);

  // R9: busy right after an acceptance
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R3 and R4: early errors never follow a table read
  a_r3_early_err_no_read: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_code == 3'd1 || rsp_code == 3'd2)) |-> !$past(mem_rd));

  // R5: the read strobe lasts one cycle
  a_r5_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R8: error flag agrees with the code
  a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_err == (rsp_code != 3'd0)));

  // R8: error responses carry a zero address
  a_r8_zero_on_err: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_paddr == '0));

  // R8: offset passes through unchanged
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> (rsp_paddr[OFF_W-1:0] == off_seen));

  // R12: only defined codes appear
  a_r12_code_range: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code <= 3'd4));

  // R8: response is a single pulse
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind segpg_xlate segpg_xlate_chk #(
  .OFF_W(OFF_W), .PA_W(PPN_W + OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .seg_we(seg_we),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_off(req_vaddr[OFF_W-1:0]), .mem_rd(mem_rd),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
);

// File: tb/sim_segpg_xlate.sv
module sim_segpg_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        seg_we;
  logic [2:0]  seg_sel;
  logic [31:0] seg_base;
  logic [18:0] seg_limit;
  logic        seg_valid;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic [2:0]  rsp_code;
  logic [29:0] rsp_paddr;

  always #4 clk = ~clk;

  segpg_xlate u0 (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_sel(seg_sel),
    .seg_base(seg_base), .seg_limit(seg_limit), .seg_valid(seg_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
  );

  // page table memory, two-cycle read latency
  logic [31:0] pt_mem [64];
  logic        d1;
  logic [31:0] a1;
  always @(posedge clk) begin
    d1         <= mem_rd;
    a1         <= mem_addr;
    mem_rvalid <= d1;
    mem_rdata  <= pt_mem[a1[7:2]];
  end

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] sh_base [8];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_seg(input logic [2:0] s, input logic [31:0] b,
                          input logic [18:0] l, input logic v);
    @(negedge clk);
    seg_we = 1'b1; seg_sel = s; seg_base = b; seg_limit = l; seg_valid = v;
    sh_base[s] = b;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  task automatic xlate(input logic [2:0] s, input logic [18:0] p, input logic [9:0] o,
                       input logic w, output logic [2:0] code, output logic err,
                       output logic [29:0] pa, output logic saw, output logic [31:0] ma,
                       output logic busy);
    logic got;
    @(negedge clk);
    req_vaddr = {s, p, o}; req_write = w; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = !req_ready;
    saw = 1'b0; ma = '0; got = 1'b0;
    code = 3'd7; err = 1'bx; pa = '1;
    for (int i = 0; i < 30 && !got; i++) begin
      if (mem_rd) begin saw = 1'b1; ma = mem_addr; end
      if (rsp_valid) begin
        got = 1'b1; code = rsp_code; err = rsp_err; pa = rsp_paddr;
      end else @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [2:0]  seg;
    logic [18:0] page;
    logic [9:0]  off;
    logic        wr;
    logic [2:0]  code;
    logic [19:0] ppn;
    logic        mem;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd7, 19'd0,       10'h000, 1'b0, 3'd1, 20'h00000, 1'b0}, // R2 reset-cleared segment
    '{3'd0, 19'd0,       10'h155, 1'b0, 3'd0, 20'h00012, 1'b1}, // R1 R8 read ok
    '{3'd0, 19'd0,       10'h3FF, 1'b1, 3'd0, 20'h00012, 1'b1}, // R8 write ok, top offset
    '{3'd0, 19'd1,       10'h001, 1'b0, 3'd0, 20'h00ABC, 1'b1}, // R7 read-only page read
    '{3'd0, 19'd1,       10'h000, 1'b1, 3'd4, 20'h00000, 1'b1}, // R7 write to read-only
    '{3'd0, 19'd2,       10'h000, 1'b0, 3'd3, 20'h00000, 1'b1}, // R6 entry invalid
    '{3'd0, 19'd3,       10'h200, 1'b0, 3'd4, 20'h00000, 1'b1}, // R7 no read right
    '{3'd0, 19'd3,       10'h200, 1'b1, 3'd0, 20'hFFFFF, 1'b1}, // R4 page equal to limit
    '{3'd0, 19'd4,       10'h000, 1'b0, 3'd2, 20'h00000, 1'b0}, // R4 one past limit
    '{3'd2, 19'd0,       10'h000, 1'b0, 3'd1, 20'h00000, 1'b0}, // R3 invalid segment
    '{3'd2, 19'd9,       10'h000, 1'b0, 3'd1, 20'h00000, 1'b0}, // R12 segment before bound
    '{3'd1, 19'd1,       10'h000, 1'b0, 3'd3, 20'h00000, 1'b1}, // R12 entry valid before perm
    '{3'd1, 19'd0,       10'h0AA, 1'b1, 3'd0, 20'h12345, 1'b1}, // R5 nonzero base
    '{3'd5, 19'd1,       10'h001, 1'b0, 3'd0, 20'h00ABC, 1'b1}  // R10 shared segment
  };

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: tag_of = "R8";
      3'd1: tag_of = "R3";
      3'd2: tag_of = "R4";
      3'd3: tag_of = "R6";
      default: tag_of = "R7";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0]  c;
    logic        e, saw, busy;
    logic [29:0] pa;
    logic [31:0] ma;

    rst = 1'b1; seg_we = 1'b0; seg_sel = '0; seg_base = '0; seg_limit = '0;
    seg_valid = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    for (int i = 0; i < 64; i++) pt_mem[i] = '0;
    for (int i = 0; i < 8; i++) sh_base[i] = '0;
    pt_mem[0]  = 32'h00012007; // V R W
    pt_mem[1]  = 32'h00ABC003; // V R
    pt_mem[2]  = 32'h00055006; // R W, not valid
    pt_mem[3]  = 32'hFFFFF005; // V W
    pt_mem[16] = 32'h12345007; // V R W
    pt_mem[17] = 32'h00001000; // nothing

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R11 ready", {63'd0, req_ready}, 64'd1);
    chk("R11 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R11 mem_rd", {63'd0, mem_rd}, 64'd0);

    load_seg(3'd0, 32'h0000_0000, 19'd3, 1'b1);
    load_seg(3'd1, 32'h0000_0040, 19'd1, 1'b1);
    load_seg(3'd2, 32'h0000_0000, 19'd3, 1'b0);
    load_seg(3'd5, 32'h0000_0000, 19'd3, 1'b1);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [29:0] exp_pa;
      t = VECS[v];
      exp_pa = (t.code == 3'd0) ? {t.ppn, t.off} : 30'd0;
      xlate(t.seg, t.page, t.off, t.wr, c, e, pa, saw, ma, busy);
      chk($sformatf("%s code v%0d", tag_of(t.code), v), {61'd0, c}, {61'd0, t.code});
      chk($sformatf("R8 err v%0d", v), {63'd0, e}, {63'd0, (t.code != 3'd0)});
      chk($sformatf("R8 paddr v%0d", v), {34'd0, pa}, {34'd0, exp_pa});
      chk($sformatf("%s read issued v%0d", t.mem ? "R5" : "R4", v),
          {63'd0, saw}, {63'd0, t.mem});
      if (t.mem)
        chk($sformatf("R5 addr v%0d", v), {32'd0, ma},
            {32'd0, sh_base[t.seg] + {11'd0, t.page, 2'b00}});
      if (v == 1) chk("R9 busy in flight", {63'd0, busy}, 64'd1);
    end

    // R9: a waiting request is held while a descriptor load is in progress
    @(negedge clk);
    seg_we = 1'b1; seg_sel = 3'd7; seg_base = 32'h40; seg_limit = 19'd0; seg_valid = 1'b1;
    sh_base[7] = 32'h40;
    req_vaddr = {3'd7, 19'd0, 10'h011}; req_write = 1'b0; req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk($sformatf("R9 stall ready k%0d", k), {63'd0, req_ready}, 64'd0);
      chk($sformatf("R9 stall no rsp k%0d", k), {63'd0, rsp_valid}, 64'd0);
    end
    seg_we = 1'b0; req_valid = 1'b0;

    // R2: newly written descriptor takes effect
    xlate(3'd7, 19'd0, 10'h011, 1'b0, c, e, pa, saw, ma, busy);
    chk("R2 loaded code", {61'd0, c}, 64'd0);
    chk("R2 loaded paddr", {34'd0, pa}, {34'd0, 20'h12345, 10'h011});
    // R4 on the reloaded segment with limit 0
    xlate(3'd7, 19'd1, 10'h000, 1'b0, c, e, pa, saw, ma, busy);
    chk("R4 limit zero", {61'd0, c}, 64'd2);

    // R2: reset clears every valid flag
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    xlate(3'd0, 19'd0, 10'h000, 1'b0, c, e, pa, saw, ma, busy);
    chk("R2 reset clears valid", {61'd0, c}, 64'd1);
    chk("R3 no read after reset", {63'd0, saw}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule